// File: doc/BRIEF.md
# DMA Request Pacer with Alternating Data Ports

This block paces a single request line toward an external DMA controller that moves 16-bit words between a host and a data buffer. A request is raised only when the buffer can take part in one whole burst. In the read direction that means the buffer already holds at least one burst of words. In the write direction it means the buffer has free space for at least one burst. After the burst's final access the request is held low for a programmable number of card clocks. It is then raised again only if the buffer still meets the threshold.

Host accesses reach the block as a strobe with an address qualifier (address bit 8). Both signals are brought into the card clock domain through a synchroniser and an edge detector. Each qualified access toggles a port select, so the controller can step through two 16-bit data ports as if they were one continuous FIFO. The block counts the accesses in each burst. It raises a sticky error flag when an access arrives while no request is pending.

Top module: `dma_req_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `dreq`, `port_sel` and `stray_err` are all 0.
- R2: In the read direction (`dir_write`=0), `buf_avail` is the number of words held. With `dma_en`=1 and no burst in progress, `dreq` rises one clock after `buf_avail` reaches the burst size. It stays 0 while `buf_avail` is below the burst size, including 0.
- R3: In the write direction (`dir_write`=1), `buf_avail` is the number of free words. `dreq` is raised when the free space is at least one burst, for example when the buffer is empty (1024 free). It stays 0 below one burst.
- R4: The burst size is `cfg[8:0]` and the low time is `cfg[15:9]`. `dreq` falls on the clock that counts the burst's last access and stays 0 for max(`cfg[15:9]`,1) cycles. It then rises again only if the threshold is met at that point.
- R5: An access with `addr_sel`=0 has no effect on `port_sel`, on the burst count or on `dreq`.
- R6: `port_sel` is 0 for the first access after enable and inverts on every qualified access.
- R7: Clearing `dma_en` forces `dreq` to 0 and `port_sel` to 0 from the next clock onward, whatever the buffer level.
- R8: A burst field of 0 acts as a burst of one word. A low-time field of 0 leaves `dreq` low for exactly one cycle.
- R9: A change of `dir_write` clears the burst count and `port_sel`, and drops `dreq` for at least one cycle.
- R10: A qualified access while `dreq` is 0 sets `stray_err`. The flag stays set until `dma_en` is cleared or the direction changes.
- R11: A qualified access takes effect on the third rising clock edge after `acc_strobe` rises. A strobe held high for several cycles counts as one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cfg | input | 16 | [8:0] burst words, [15:9] low time in clocks |
| dma_en | input | 1 | Enables the request line |
| dir_write | input | 1 | 0 = read from receive buffer, 1 = write to transmit buffer |
| buf_avail | input | LVL_W | Words held (read) or words free (write) |
| acc_strobe | input | 1 | Host access strobe, asynchronous |
| addr_sel | input | 1 | Address bit 8 qualifier, stable while strobe is high |
| dreq | output | 1 | DMA request |
| port_sel | output | 1 | Data port for the next access (0 or 1) |
| stray_err | output | 1 | Sticky flag: an access arrived with no request |

## Verification
Each output has a fixed latency. A threshold change or an enable change shows on `dreq` one clock later. An access shows on `port_sel`, `dreq` and `stray_err` at the third rising edge after the strobe rises. The low time after a burst is measured from that same edge. The bench drives inputs on falling edges and counts rising edges explicitly. It samples at the falling edge that follows the edge on which a result is due, so each check lands exactly in the cycle where the value changes. For the low time, the bench counts the number of falling edges at which `dreq` reads 0, starting from the edge that counts the last access.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int BURST_W = 9;
  localparam int GAP_W   = 7;
  localparam int CFG_W   = BURST_W + GAP_W;

  typedef enum logic [1:0] {
    RQ_IDLE   = 2'd0,
    RQ_ASSERT = 2'd1,
    RQ_GAP    = 2'd2
  } rq_state_e;

  // Burst field of zero is treated as a single word.
  function automatic logic [BURST_W-1:0] burst_words(input logic [CFG_W-1:0] cfg);
    burst_words = (cfg[BURST_W-1:0] == '0) ? BURST_W'(1) : cfg[BURST_W-1:0];
  endfunction

  function automatic logic [GAP_W-1:0] gap_cycles(input logic [CFG_W-1:0] cfg);
    gap_cycles = cfg[CFG_W-1:BURST_W];
  endfunction

  function automatic logic level_meets(input logic [31:0] avail, input logic [BURST_W-1:0] burst);
    level_meets = (avail >= 32'(burst));
  endfunction

endpackage

// File: rtl/dma_access_sync.sv
module dma_access_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic addr_q,
  output logic hit
);

  logic [STAGES:0]   stb_pipe;
  logic [STAGES-1:0] adr_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_pipe <= '0;
      adr_pipe <= '0;
    end else begin
      stb_pipe <= {stb_pipe[STAGES-1:0], strobe};
      adr_pipe <= {adr_pipe[STAGES-2:0], addr_q};
    end
  end

  // rising edge of the synchronised strobe, qualified by the address bit
  assign hit = stb_pipe[STAGES-1] & ~stb_pipe[STAGES] & adr_pipe[STAGES-1];

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/dma_access_ctr.sv
module dma_access_ctr
  import dma_req_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               hit,
  input  logic               dreq,
  input  logic [BURST_W-1:0] burst,
  output logic               port_sel,
  output logic               burst_done,
  output logic               stray_err
);

  logic [BURST_W-1:0] cnt;
  logic               last;

  assign last       = (cnt >= burst - 1'b1);
  assign burst_done = hit & dreq & ~clr & last;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt       <= '0;
      port_sel  <= 1'b0;
      stray_err <= 1'b0;
    end else begin
      if (hit) port_sel <= ~port_sel;
      if (hit && dreq) cnt <= last ? '0 : cnt + 1'b1;
      if (hit && !dreq) stray_err <= 1'b1;
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stray_err && !clr) |=> stray_err);

endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             thr,
  input  logic             burst_done,
  input  logic [GAP_W-1:0] gap,
  output logic             dreq
);

  rq_state_e        state;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state   <= RQ_IDLE;
      gap_cnt <= '0;
    end else begin
      unique case (state)
        RQ_IDLE:   if (thr) state <= RQ_ASSERT;
        RQ_ASSERT: if (burst_done) begin
          if (gap == '0) state <= RQ_IDLE;
          else begin
            state   <= RQ_GAP;
            gap_cnt <= gap;
          end
        end
        RQ_GAP: begin
          if (gap_cnt <= GAP_W'(1)) state <= thr ? RQ_ASSERT : RQ_IDLE;
          else gap_cnt <= gap_cnt - 1'b1;
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  assign dreq = (state == RQ_ASSERT);

  a_r4_drop_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !dreq);

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int LVL_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             dma_en,
  input  logic             dir_write,
  input  logic [LVL_W-1:0] buf_avail,
  input  logic             acc_strobe,
  input  logic             addr_sel,
  output logic             dreq,
  output logic             port_sel,
  output logic             stray_err
);

  logic               dir_q;
  logic               dir_flip;
  logic               clr;
  logic               thr;
  logic               hit;
  logic               burst_done;
  logic [BURST_W-1:0] burst;
  logic [GAP_W-1:0]   gap;

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_write;
  end

  assign dir_flip = dir_q ^ dir_write;
  assign clr      = ~dma_en | dir_flip;
  assign burst    = burst_words(cfg);
  assign gap      = gap_cycles(cfg);
  assign thr      = level_meets(32'(buf_avail), burst);

  dma_access_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (acc_strobe),
    .addr_q (addr_sel),
    .hit    (hit)
  );

  dma_access_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .hit        (hit),
    .dreq       (dreq),
    .burst      (burst),
    .port_sel   (port_sel),
    .burst_done (burst_done),
    .stray_err  (stray_err)
  );

  dma_req_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .thr        (thr),
    .burst_done (burst_done),
    .gap        (gap),
    .dreq       (dreq)
  );

  a_r2_rise_needs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> $past(thr));

  a_r5_idle_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> $stable(port_sel));

  a_r6_port_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (port_sel != $past(port_sel)));

  a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (!dreq && !port_sel));

  a_r9_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flip |=> (!port_sel && !dreq && !stray_err));

  a_r10_err_on_stray: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !dreq && !clr) |=> stray_err);

endmodule

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg;
  logic        en;
  logic        dir;
  logic [10:0] avail;
  logic        strobe;
  logic        addr;
  logic        dreq;
  logic        port_sel;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_req_gen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .dma_en     (en),
    .dir_write  (dir),
    .buf_avail  (avail),
    .acc_strobe (strobe),
    .addr_sel   (addr),
    .dreq       (dreq),
    .port_sel   (port_sel),
    .stray_err  (err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input int g, input int b, input logic w, input int lvl);
    @(negedge clk);
    en = 1'b0; cfg = {7'(g), 9'(b)}; dir = w; avail = 11'(lvl);
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  // strobe high for three rising edges; returns at the falling edge after the counting edge
  task automatic acc(input logic a8);
    @(negedge clk);
    strobe = 1'b1; addr = a8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    strobe = 1'b0; addr = 1'b0;
  endtask

  task automatic pause();
    repeat (2) @(negedge clk);
  endtask

  task automatic low_len(output int n);
    n = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dreq) break;
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 dreq in reset", dreq, 0);
    chk("R1 port in reset", port_sel, 0);
    chk("R1 err in reset", err, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dreq after reset", dreq, 0);
    chk("R1 port after reset", port_sel, 0);
  endtask

  task automatic t_read_threshold();
    setup(0, 8, 1'b0, 0);
    chk("R2 empty read buffer", dreq, 0);
    avail = 11'd7;
    repeat (3) @(negedge clk);
    chk("R2 below burst", dreq, 0);
    avail = 11'd8;
    @(negedge clk);
    chk("R2 at burst", dreq, 1);
  endtask

  task automatic t_write_threshold();
    setup(2, 16, 1'b1, 15);
    repeat (2) @(negedge clk);
    chk("R3 free space below burst", dreq, 0);
    avail = 11'd1024;
    @(negedge clk);
    chk("R3 empty transmit buffer", dreq, 1);
  endtask

  task automatic t_burst_gap();
    int n;
    setup(5, 4, 1'b0, 8);
    chk("R2 burst ready", dreq, 1);
    for (int i = 1; i <= 3; i++) begin
      acc(1'b1);
      chk("R6 port alternates", port_sel, i % 2);
      chk("R4 request held in burst", dreq, 1);
      pause();
    end
    acc(1'b1);
    chk("R4 drop at burst end", dreq, 0);
    chk("R6 port after even count", port_sel, 0);
    chk("R10 no error in normal burst", err, 0);
    low_len(n);
    chk("R4 low time", n, 5);
    chk("R4 re-raise with threshold", dreq, 1);
    for (int i = 1; i <= 3; i++) begin
      acc(1'b1);
      pause();
    end
    avail = 11'd2;
    acc(1'b1);
    repeat (10) @(negedge clk);
    chk("R4 stays low without threshold", dreq, 0);
  endtask

  task automatic t_addr_ignore();
    setup(3, 2, 1'b0, 8);
    acc(1'b0);
    chk("R5 port unchanged", port_sel, 0);
    chk("R5 request unchanged", dreq, 1);
    chk("R5 no error", err, 0);
    pause();
    acc(1'b1);
    chk("R5 count not advanced", dreq, 1);
    chk("R6 first port access", port_sel, 1);
    pause();
    acc(1'b1);
    chk("R5 burst ends on second port access", dreq, 0);
  endtask

  task automatic t_zero_fields();
    int n;
    setup(0, 0, 1'b0, 1);
    chk("R8 one-word burst ready", dreq, 1);
    acc(1'b1);
    chk("R8 one access ends burst", dreq, 0);
    low_len(n);
    chk("R8 zero gap one cycle", n, 1);
  endtask

  task automatic t_disable();
    setup(4, 4, 1'b0, 8);
    acc(1'b1);
    chk("R6 port after one access", port_sel, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R7 request forced low", dreq, 0);
    chk("R7 port cleared", port_sel, 0);
    repeat (3) @(negedge clk);
    chk("R7 held low while disabled", dreq, 0);
  endtask

  task automatic t_dir_change();
    setup(4, 4, 1'b0, 8);
    acc(1'b1);
    chk("R9 port before flip", port_sel, 1);
    dir = 1'b1;
    @(negedge clk);
    chk("R9 port cleared", port_sel, 0);
    chk("R9 request dropped", dreq, 0);
    @(negedge clk);
    chk("R9 request back", dreq, 1);
    for (int i = 0; i < 3; i++) begin
      acc(1'b1);
      pause();
    end
    chk("R9 count restarted", dreq, 1);
  endtask

  task automatic t_stray();
    setup(0, 4, 1'b0, 0);
    chk("R10 no request", dreq, 0);
    acc(1'b1);
    chk("R10 error set", err, 1);
    chk("R6 stray still toggles", port_sel, 1);
    repeat (3) @(negedge clk);
    chk("R10 error sticky", err, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R10 error cleared by disable", err, 0);
  endtask

  task automatic t_sync_latency();
    setup(0, 2, 1'b0, 8);
    strobe = 1'b1; addr = 1'b1;
    @(negedge clk);
    chk("R11 not after edge 1", port_sel, 0);
    @(negedge clk);
    chk("R11 not after edge 2", port_sel, 0);
    @(negedge clk);
    chk("R11 counted on edge 3", port_sel, 1);
    repeat (3) @(negedge clk);
    chk("R11 long strobe counted once", port_sel, 1);
    strobe = 1'b0; addr = 1'b0;
    pause();
  endtask

  initial begin : wdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg = '0; en = 1'b0; dir = 1'b0;
    avail = '0; strobe = 1'b0; addr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_read_threshold();
    t_write_threshold();
    t_burst_gap();
    t_addr_ignore();
    t_zero_fields();
    t_disable();
    t_dir_change();
    t_stray();
    t_sync_latency();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule